// File: doc/BRIEF.md
# Column-Parallel 3x3 Mean Filter Array

This block computes a 3x3 box average over an image, one full image line per step. The array has one processing element for each image column, 128 by default. On every accepted line each element takes the 8-bit pixel of its own column. It keeps the two previous pixels of that column and sums the three values vertically. It then adds the vertical sums of its two adjacent elements, so the horizontal extent of the window comes from the chain of elements and not from a raster line buffer. The nine-pixel total is divided by nine, with truncation, and registered as the output pixel of that column.

A frame begins with a frame-start pulse. Each accepted line after that moves the vertical window down one row. The first two lines of a frame produce no output. From the third line on, each accepted line emits the filtered version of the line before it, so the first and last lines of a frame are never emitted. Columns at the two ends of the chain treat the vertical sum of the missing neighbour as zero and still divide by nine. Line steps may be separated by any number of idle cycles, and there is no backpressure.

Top module: `col_avg3_array`

## Requirements
- R1: While reset is asserted and until the first output is produced, `out_valid_o` is 0 and every pixel of `pix_o` is 0.
- R2: For an interior column c, the output for line i is floor((sum of the pixels in lines i-1..i+1 and columns c-1..c+1) / 9). It appears on `pix_o` with `out_valid_o` high in the cycle after line i+1 is accepted.
- R3: The first and second lines accepted after a frame start raise no `out_valid_o`. The third accepted line is the first one that produces an output, and that output is for line 1.
- R4: Column 0 and column N-1 use only the columns that exist (two columns, six pixels), and the sum is still divided by 9.
- R5: A frame start clears the line history. If it arrives together with a valid line, that line is taken as line 0 of the new frame. The cycle after a frame start never carries `out_valid_o`.
- R6: A cycle with `line_valid_i` low changes nothing. `out_valid_o` is low in the following cycle, `pix_o` holds its value, and the next accepted line continues the same window.
- R7: No sum overflows. A frame of all 255 gives 255 in interior columns and 170 in end columns.
- R8: `out_valid_o` is high for exactly one cycle for each line that produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse that begins a new frame |
| line_valid_i | input | 1 | Accept `pix_i` as the next image line |
| pix_i | input | N_COLS*8 | Input line; column c occupies bits [8c+7:8c] |
| pix_o | output | N_COLS*8 | Filtered line; column c occupies bits [8c+7:8c] |
| out_valid_o | output | 1 | `pix_o` holds a new filtered line this cycle |

## Verification
A frame start and a valid line can land in the same cycle. The block must then drop the old history and take the incoming line as row 0, not as the next row of the old frame. The bench drives that case at the start of a frame and also in the middle of a running frame, where the counter already allows output. It then checks that the next two accepted lines produce no output and that the third produces the mean of the new rows only. Idle gaps between lines are interleaved in the same runs to show that holding the history does not disturb the window.

// File: rtl/avg3_pkg.sv
package avg3_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned CSUM_W = PIX_W + 2;  // three pixels
  localparam int unsigned TOT_W  = PIX_W + 4;  // nine pixels
  localparam int unsigned CNT_W  = 2;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [CSUM_W-1:0] csum_t;
  typedef logic [TOT_W-1:0]  tot_t;
endpackage

// File: rtl/avg3_div9.sv
module avg3_div9
  import avg3_pkg::*;
(
  input  tot_t tot_i,
  output pix_t quot_o
);
  localparam int unsigned RECIP     = 3641;  // ceil(2^15/9)
  localparam int unsigned SHIFT     = 15;
  localparam int unsigned PROD_W    = TOT_W + 12;

  generate
    if (TOT_W <= 12) begin : g_recip
      // exact floor for every total below 4096
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(tot_i) * PROD_W'(RECIP);
      assign quot_o = prod[SHIFT +: PIX_W];
    end else begin : g_div
      tot_t q;
      assign q      = tot_i / TOT_W'(9);
      assign quot_o = q[PIX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/avg3_line_ctrl.sv
module avg3_line_ctrl
  import avg3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic line_valid_i,
  output logic emit_o,
  output logic out_valid_o
);
  logic [CNT_W-1:0] cnt_q;

  assign emit_o = line_valid_i && !frame_start_i && (cnt_q == CNT_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= emit_o;
      if (frame_start_i)
        cnt_q <= line_valid_i ? CNT_W'(1) : CNT_W'(0);
      else if (line_valid_i && cnt_q != CNT_W'(2))
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(2));
  assert_fs_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cnt_q <= CNT_W'(1));
  assert_fs_no_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !out_valid_o);
  assert_idle_no_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_i |=> !out_valid_o);
endmodule

// File: rtl/avg3_pe.sv
module avg3_pe
  import avg3_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  take_i,
  input  logic  emit_i,
  input  pix_t  pix_i,
  input  csum_t left_sum_i,
  input  csum_t right_sum_i,
  output csum_t col_sum_o,
  output pix_t  pix_o
);
  pix_t hist_q1;  // line i
  pix_t hist_q2;  // line i-1
  tot_t total;
  pix_t quot;

  assign col_sum_o = CSUM_W'(hist_q2) + CSUM_W'(hist_q1) + CSUM_W'(pix_i);
  assign total     = TOT_W'(left_sum_i) + TOT_W'(col_sum_o) + TOT_W'(right_sum_i);

  avg3_div9 u_div (
    .tot_i  (total),
    .quot_o (quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q1 <= '0;
      hist_q2 <= '0;
      pix_o   <= '0;
    end else begin
      if (clear_i) begin
        hist_q2 <= '0;
        hist_q1 <= take_i ? pix_i : '0;
      end else if (take_i) begin
        hist_q2 <= hist_q1;
        hist_q1 <= pix_i;
      end
      if (emit_i) pix_o <= quot;
    end
  end

  assert_div_trunc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (int'(quot) * 9 <= int'(total)) && (int'(total) < int'(quot) * 9 + 9));
  assert_hist_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !take_i) |=> (hist_q1 == '0) && (hist_q2 == '0));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clear_i) |=> $stable(hist_q1) && $stable(hist_q2));
  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(pix_o));
endmodule

// File: rtl/col_avg3_array.sv
module col_avg3_array
  import avg3_pkg::*;
#(
  parameter int unsigned N_COLS = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic                     line_valid_i,
  input  logic [N_COLS*PIX_W-1:0]  pix_i,
  output logic [N_COLS*PIX_W-1:0]  pix_o,
  output logic                     out_valid_o
);
  csum_t sums [N_COLS];
  logic  emit;

  avg3_line_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_valid_i  (line_valid_i),
    .emit_o        (emit),
    .out_valid_o   (out_valid_o)
  );

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    csum_t left_sum, right_sum;

    if (c == 0) begin : g_lend
      assign left_sum = '0;
    end else begin : g_lnb
      assign left_sum = sums[c-1];
    end
    if (c == N_COLS - 1) begin : g_rend
      assign right_sum = '0;
    end else begin : g_rnb
      assign right_sum = sums[c+1];
    end

    avg3_pe u_pe (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (frame_start_i),
      .take_i      (line_valid_i),
      .emit_i      (emit),
      .pix_i       (pix_i[c*PIX_W +: PIX_W]),
      .left_sum_i  (left_sum),
      .right_sum_i (right_sum),
      .col_sum_o   (sums[c]),
      .pix_o       (pix_o[c*PIX_W +: PIX_W])
    );
  end
endmodule

// File: tb/tb_col_avg3_array.sv
module tb_col_avg3_array;
  localparam int N          = 128;
  localparam int PW         = 8;
  localparam int MAXL       = 12;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            frame_start_i = 1'b0;
  logic            line_valid_i = 1'b0;
  logic [N*PW-1:0] pix_i = '0;
  logic [N*PW-1:0] pix_o;
  logic            out_valid_o;

  logic [7:0] img [MAXL][N];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  col_avg3_array #(.N_COLS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .line_valid_i(line_valid_i), .pix_i(pix_i), .pix_o(pix_o),
    .out_valid_o(out_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_pix(int row, int col);
    int s = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (col + dc >= 0 && col + dc < N) s += img[row+dr][col+dc];
    return s / 9;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_random(int n);
    for (int r = 0; r < n; r++)
      for (int c = 0; c < N; c++) img[r][c] = 8'($urandom);
  endtask

  task automatic fill_const(int n, int v);
    for (int r = 0; r < n; r++)
      for (int c = 0; c < N; c++) img[r][c] = 8'(v);
  endtask

  // drive at negedge, return at next negedge with outputs settled
  task automatic step(bit fs, bit lv, int row);
    frame_start_i = fs;
    line_valid_i  = lv;
    if (lv) for (int c = 0; c < N; c++) pix_i[c*PW +: PW] = img[row][c];
    @(negedge clk);
    frame_start_i = 1'b0;
    line_valid_i  = 1'b0;
  endtask

  task automatic run_frame(int n, bit fs_with_line, int gap, string tag);
    logic [N*PW-1:0] snap;
    if (!fs_with_line) begin
      step(1'b1, 1'b0, 0);
      check(out_valid_o == 1'b0, "R5 fs cycle", int'(out_valid_o), 0);
    end
    for (int k = 0; k < n; k++) begin
      step(fs_with_line && k == 0, 1'b1, k);
      if (k < 2) begin
        check(out_valid_o == 1'b0, "R3 first lines", int'(out_valid_o), 0);
      end else begin
        check(out_valid_o == 1'b1, "R2 valid", int'(out_valid_o), 1);
        for (int c = 0; c < N; c++) begin
          int e = exp_pix(k - 1, c);
          int a = int'(pix_o[c*PW +: PW]);
          if (tag != "")      check(a == e, tag, a, e);
          else if (c == 0 || c == N - 1) check(a == e, "R4 edge", a, e);
          else                check(a == e, "R2 interior", a, e);
        end
      end
      snap = pix_o;
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0, 0);
        check(out_valid_o == 1'b0, "R8 single pulse", int'(out_valid_o), 0);
        check(pix_o == snap, "R6 hold", int'(pix_o[PW-1:0]), int'(snap[PW-1:0]));
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1d3a_5c71));
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0 && pix_o == '0, "R1 in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0 && pix_o == '0, "R1 after reset", int'(out_valid_o), 0);

    fill_random(8);
    run_frame(8, 1'b0, 0, "");
    check(out_valid_o == 1'b1, "R8 last line emits", int'(out_valid_o), 1);
    step(1'b0, 1'b0, 0);
    check(out_valid_o == 1'b0, "R8 drop", int'(out_valid_o), 1'b0);

    fill_random(6);
    run_frame(6, 1'b1, 2, "");

    fill_const(5, 255);
    run_frame(5, 1'b0, 1, "R7 saturate");
    check(int'(pix_o[PW-1:0]) == 170, "R7 edge 170", int'(pix_o[PW-1:0]), 170);
    check(int'(pix_o[PW +: PW]) == 255, "R7 interior 255", int'(pix_o[PW +: PW]), 255);

    // abort mid-frame, restart with frame start on the same cycle as a line
    fill_random(4);
    run_frame(4, 1'b1, 0, "");
    fill_const(5, 100);
    run_frame(5, 1'b1, 0, "R5 restart");
    check(int'(pix_o[(N-1)*PW +: PW]) == 66, "R4 edge 66", int'(pix_o[(N-1)*PW +: PW]), 66);

    // single hot column at the left edge
    fill_const(4, 0);
    for (int r = 0; r < 4; r++) img[r][0] = 8'd255;
    run_frame(4, 1'b0, 0, "");
    check(int'(pix_o[PW-1:0]) == 85, "R4 hot edge", int'(pix_o[PW-1:0]), 85);

    fill_random(MAXL);
    run_frame(MAXL, 1'b1, 3, "");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule